// File: doc/BRIEF.md
# Programmable Crosspoint Output Cell

This block is a single output cell of a digital signal-routing crosspoint. A bank of routed source signals enters every cell. Four configured legs each pick one of those sources, and two dynamic select inputs choose among the four legs at run time. Four cells can be chained through cascade ports to form a 16:1 selection. The selected signal then goes through one of three paths: straight through, through a level-sensitive latch, or through a clock-enabled register. The output stage is tri-stated by an output-enable input. It can also be driven all the time, or tied to a constant LOW or HIGH.

Each of the five control inputs (output enable, storage clock, clock enable and the two selects) has its own polarity bit, so it can be used active-high or active-low. The whole cell is set up through one configuration word, written with a write-enable strobe. The storage clock is an ordinary routed signal. It is sampled by the system clock, and the cell acts on its levels and rising edges, so the block has a single clock domain.

Top module: `xpt_cell`

## Requirements
- R1: While `cfg_we_i` is high at a rising edge of `clk_i`, `cfg_wdata_i` is loaded and takes effect right after that edge, not before. Word layout, with S = clog2(N_SRC):
  - leg k (k = 0..3) occupies bits [k*S +: S].
  - Polarity bits start at 4*S, in this order: output enable, storage clock, clock enable, select 0, select 1.
  - The path field (2 bits) is at 4*S+5.
  - The output mode field (2 bits) is at 4*S+7.
  - The expander enable is at 4*S+9.
- R2: `pad_oe_o` is 0 while `rst_i` is high, and stays 0 after reset until the first configuration write.
- R3: Leg k carries `src_i[leg k index]`. Any source may feed several legs at the same time.
- R4: The leg index is {`mux1_i` XOR its polarity bit, `mux0_i` XOR its polarity bit}.
- R5: With the expander enable at 1, `sel_hi_i` chooses the routed signal: 0 gives the local 4:1 result, and k = 1..3 gives `casc_i[k-1]`. With the expander enable at 0, `sel_hi_i` has no effect. `casc_o` always carries the local 4:1 result.
- R6: Path 0 (direct) presents the routed signal combinationally.
- R7: Path 1 (latch) is transparent while the effective storage clock is 1. While it is 0, the latch holds the value it had at the last system-clock edge where the effective storage clock was 1.
- R8: Path 2 or 3 (register) captures the routed signal at a system-clock edge where the effective storage clock is 1, it was 0 at the previous edge, and the effective clock enable is 1. The previous level counts as 1 right after reset.
- R9: While the effective clock enable is 0, the register holds its value across storage-clock rising edges.
- R10: In output mode 0, `pad_oe_o` equals `cell_oe_i` XOR its polarity bit.
- R11: Output mode 1 drives the pad at all times. Mode 2 drives a constant 0 and mode 3 drives a constant 1, whatever the selection and storage do.
- R12: Reset clears the latch and register contents to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4*S+10 | Configuration word |
| src_i | input | N_SRC | Routed source signals |
| mux0_i | input | 1 | Dynamic select bit 0 |
| mux1_i | input | 1 | Dynamic select bit 1 |
| sel_hi_i | input | 2 | Group select for 16:1 expansion |
| casc_i | input | 3 | Neighbour cells' local results |
| cell_clk_i | input | 1 | Storage clock / latch gate |
| cell_cen_i | input | 1 | Storage clock enable |
| cell_oe_i | input | 1 | Output enable |
| casc_o | output | 1 | Local 4:1 result for neighbours |
| pad_o | output | 1 | Output data |
| pad_oe_o | output | 1 | Output driver enable (0 = high impedance) |

## Verification
The bench builds the cell with N_SRC = 4, which gives 2-bit leg fields. With that size, the sweep covers all 256 leg assignments against all 16 source patterns and all four select values, including every shared-source fan-out case. The expander is swept over every group select, cascade pattern and local selection. The sweep also covers every polarity setting of the selects and of output enable. Directed sequences cover latch transparency and hold, register capture under both clock polarities, clock-enable hold, reset clearing and the one-edge configuration latency.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    typedef enum logic [1:0] {
        PATH_DIRECT = 2'd0,
        PATH_LATCH  = 2'd1,
        PATH_REG    = 2'd2,
        PATH_REG2   = 2'd3
    } path_e;

    typedef enum logic [1:0] {
        OUT_OE   = 2'd0,
        OUT_ON   = 2'd1,
        OUT_LOW  = 2'd2,
        OUT_HIGH = 2'd3
    } omode_e;

    typedef struct packed {
        logic mux1;
        logic mux0;
        logic cen;
        logic clk;
        logic oe;
    } inv_t;

    localparam int INV_W  = 5;
    localparam int CTRL_W = INV_W + 2 + 2 + 1;

endpackage

// File: rtl/xpt_cfg_reg.sv
module xpt_cfg_reg #(
    parameter int W = 22
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] word_o,
    output logic         valid_o
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         valid;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.word  = wdata_i;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o  = st_q.word;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/xpt_sel.sv
module xpt_sel #(
    parameter int N_SRC = 8,
    parameter int SRC_W = 3,
    parameter int N_LEG = 4
) (
    input  logic [N_SRC-1:0]       src_i,
    input  logic [N_LEG*SRC_W-1:0] legs_i,
    input  logic [1:0]             sel_i,
    input  logic                   exp_en_i,
    input  logic [1:0]             sel_hi_i,
    input  logic [N_LEG-2:0]       casc_i,
    output logic                   local_o,
    output logic                   routed_o
);
    logic [N_LEG-1:0] leg_val;

    for (genvar k = 0; k < N_LEG; k++) begin : g_leg
        logic [SRC_W-1:0] idx;
        assign idx = legs_i[k*SRC_W +: SRC_W];
        always_comb begin
            leg_val[k] = 1'b0;
            for (int s = 0; s < N_SRC; s++) begin
                if (idx == SRC_W'(s)) leg_val[k] = src_i[s];
            end
        end
    end

    always_comb begin
        local_o = leg_val[sel_i];
    end

    always_comb begin
        routed_o = local_o;
        if (exp_en_i) begin
            case (sel_hi_i)
                2'd0:    routed_o = local_o;
                2'd1:    routed_o = casc_i[0];
                2'd2:    routed_o = casc_i[1];
                default: routed_o = casc_i[2];
            endcase
        end
    end
endmodule

// File: rtl/xpt_store.sv
module xpt_store
    import xpt_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  path_e path_i,
    input  logic  eclk_i,
    input  logic  ecen_i,
    input  logic  din_i,
    output logic  dout_o
);
    typedef struct packed {
        logic hold;
        logic clk_prev;
    } store_state_t;

    store_state_t st_d, st_q;
    logic is_reg;
    logic rise;

    assign is_reg = (path_i == PATH_REG) || (path_i == PATH_REG2);
    assign rise   = eclk_i && !st_q.clk_prev;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = eclk_i;
        if (path_i == PATH_LATCH && eclk_i) begin
            st_d.hold = din_i;
        end else if (is_reg && rise && ecen_i) begin
            st_d.hold = din_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.hold     <= 1'b0;
            st_q.clk_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (path_i)
            PATH_DIRECT: dout_o = din_i;
            PATH_LATCH:  dout_o = eclk_i ? din_i : st_q.hold;
            default:     dout_o = st_q.hold;
        endcase
    end
endmodule

// File: rtl/xpt_drive.sv
module xpt_drive
    import xpt_pkg::*;
(
    input  logic   rst_i,
    input  logic   valid_i,
    input  omode_e omode_i,
    input  logic   eoe_i,
    input  logic   din_i,
    output logic   pad_o,
    output logic   pad_oe_o
);
    always_comb begin
        pad_oe_o = 1'b0;
        pad_o    = 1'b0;
        if (valid_i && !rst_i) begin
            case (omode_i)
                OUT_OE:   begin pad_oe_o = eoe_i; pad_o = din_i; end
                OUT_ON:   begin pad_oe_o = 1'b1;  pad_o = din_i; end
                OUT_LOW:  begin pad_oe_o = 1'b1;  pad_o = 1'b0;  end
                default:  begin pad_oe_o = 1'b1;  pad_o = 1'b1;  end
            endcase
        end
    end
endmodule

// File: rtl/xpt_cell.sv
module xpt_cell
    import xpt_pkg::*;
#(
    parameter  int N_SRC = 8,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int LEG_W = 4 * SRC_W,
    localparam int CFG_W = LEG_W + CTRL_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic [N_SRC-1:0] src_i,
    input  logic             mux0_i,
    input  logic             mux1_i,
    input  logic [1:0]       sel_hi_i,
    input  logic [2:0]       casc_i,
    input  logic             cell_clk_i,
    input  logic             cell_cen_i,
    input  logic             cell_oe_i,
    output logic             casc_o,
    output logic             pad_o,
    output logic             pad_oe_o
);
    logic [CFG_W-1:0] cfg_word;
    logic             cfg_valid;
    logic [LEG_W-1:0] legs;
    inv_t             inv;
    path_e            path;
    omode_e           omode;
    logic             exp_en;
    logic [1:0]       sel_eff;
    logic             eclk;
    logic             ecen;
    logic             eoe;
    logic             sel_local;
    logic             sel_out;
    logic             store_out;

    xpt_cfg_reg #(.W(CFG_W)) i_cfg (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .word_o  (cfg_word),
        .valid_o (cfg_valid)
    );

    assign legs   = cfg_word[LEG_W-1:0];
    assign inv    = inv_t'(cfg_word[LEG_W +: INV_W]);
    assign path   = path_e'(cfg_word[LEG_W+INV_W +: 2]);
    assign omode  = omode_e'(cfg_word[LEG_W+INV_W+2 +: 2]);
    assign exp_en = cfg_word[LEG_W+INV_W+4];

    assign sel_eff = {mux1_i ^ inv.mux1, mux0_i ^ inv.mux0};
    assign eclk    = cell_clk_i ^ inv.clk;
    assign ecen    = cell_cen_i ^ inv.cen;
    assign eoe     = cell_oe_i ^ inv.oe;

    xpt_sel #(.N_SRC(N_SRC), .SRC_W(SRC_W), .N_LEG(4)) i_sel (
        .src_i    (src_i),
        .legs_i   (legs),
        .sel_i    (sel_eff),
        .exp_en_i (exp_en),
        .sel_hi_i (sel_hi_i),
        .casc_i   (casc_i),
        .local_o  (sel_local),
        .routed_o (sel_out)
    );

    assign casc_o = sel_local;

    xpt_store i_store (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .path_i (path),
        .eclk_i (eclk),
        .ecen_i (ecen),
        .din_i  (sel_out),
        .dout_o (store_out)
    );

    xpt_drive i_drive (
        .rst_i    (rst_i),
        .valid_i  (cfg_valid),
        .omode_i  (omode),
        .eoe_i    (eoe),
        .din_i    (store_out),
        .pad_o    (pad_o),
        .pad_oe_o (pad_oe_o)
    );
endmodule

// File: rtl/xpt_cell_chk.sv
module xpt_cell_chk
    import xpt_pkg::*;
(
    input logic   clk_i,
    input logic   rst_i,
    input logic   cfg_we_i,
    input logic   cfg_valid,
    input path_e  path,
    input omode_e omode,
    input inv_t   inv,
    input logic   cell_clk_i,
    input logic   cell_cen_i,
    input logic   cell_oe_i,
    input logic   sel_out,
    input logic   store_out,
    input logic   pad_o,
    input logic   pad_oe_o
);
    logic eclk, ecen, is_reg, eclk_prev;

    assign eclk   = cell_clk_i ^ inv.clk;
    assign ecen   = cell_cen_i ^ inv.cen;
    assign is_reg = (path == PATH_REG) || (path == PATH_REG2);

    always_ff @(posedge clk_i) begin
        if (rst_i) eclk_prev <= 1'b1;
        else       eclk_prev <= eclk;
    end

    assert_reset_hiz_R2: assert property (@(posedge clk_i)
        rst_i |-> !pad_oe_o);

    assert_unloaded_hiz_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !cfg_valid |-> !pad_oe_o);

    assert_direct_path_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_valid && path == PATH_DIRECT && (omode == OUT_OE || omode == OUT_ON))
        |-> (pad_o == sel_out));

    assert_latch_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && path == PATH_LATCH && $past(path == PATH_LATCH)
         && !eclk && !$past(eclk)) |-> $stable(store_out));

    assert_reg_capture_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (is_reg && !cfg_we_i && ecen && eclk && !eclk_prev)
        |=> (store_out == $past(sel_out)));

    assert_cen_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && is_reg && $past(is_reg) && !$past(ecen))
        |-> $stable(store_out));

    assert_oe_ctrl_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_valid && omode == OUT_OE) |-> (pad_oe_o == (cell_oe_i ^ inv.oe)));

    assert_force_high_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_valid && omode == OUT_HIGH) |-> (pad_oe_o && pad_o));

    assert_force_low_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_valid && omode == OUT_LOW) |-> (pad_oe_o && !pad_o));
endmodule

bind xpt_cell xpt_cell_chk i_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_valid  (cfg_valid),
    .path       (path),
    .omode      (omode),
    .inv        (inv),
    .cell_clk_i (cell_clk_i),
    .cell_cen_i (cell_cen_i),
    .cell_oe_i  (cell_oe_i),
    .sel_out    (sel_out),
    .store_out  (store_out),
    .pad_o      (pad_o),
    .pad_oe_o   (pad_oe_o)
);

// File: tb/test_xpt_cell.sv
module test_xpt_cell;
    localparam int N_SRC = 4;
    localparam int CFG_W = 18;

    logic             clk = 1'b0;
    logic             rst_i;
    logic             cfg_we_i;
    logic [CFG_W-1:0] cfg_wdata_i;
    logic [N_SRC-1:0] src_i;
    logic             mux0_i, mux1_i;
    logic [1:0]       sel_hi_i;
    logic [2:0]       casc_i;
    logic             cell_clk_i, cell_cen_i, cell_oe_i;
    logic             casc_o, pad_o, pad_oe_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    xpt_cell #(.N_SRC(N_SRC)) i_xpt_cell (
        .clk_i(clk), .rst_i(rst_i), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .src_i(src_i), .mux0_i(mux0_i), .mux1_i(mux1_i), .sel_hi_i(sel_hi_i),
        .casc_i(casc_i), .cell_clk_i(cell_clk_i), .cell_cen_i(cell_cen_i),
        .cell_oe_i(cell_oe_i), .casc_o(casc_o), .pad_o(pad_o), .pad_oe_o(pad_oe_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [CFG_W-1:0] mk(input logic [7:0] legs, input logic [4:0] inv,
                                            input logic [1:0] path, input logic [1:0] om,
                                            input logic ex);
        return {ex, om, path, inv, legs};
    endfunction

    function automatic logic pick(input logic [3:0] src, input logic [7:0] legs,
                                  input logic [1:0] idx);
        return src[legs[2*idx +: 2]];
    endfunction

    // drive a config word across one rising edge, return at the falling edge
    task automatic load(input logic [CFG_W-1:0] w);
        cfg_wdata_i = w;
        cfg_we_i    = 1'b1;
        @(negedge clk);
        cfg_we_i    = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_i = 1'b1; cfg_we_i = 1'b0; cfg_wdata_i = '0; src_i = '0;
        mux0_i = 0; mux1_i = 0; sel_hi_i = '0; casc_i = '0;
        cell_clk_i = 0; cell_cen_i = 1; cell_oe_i = 1;
        repeat (3) @(negedge clk);
        chk("R2 reset oe", pad_oe_o, 1'b0);
        rst_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 unconfigured oe", pad_oe_o, 1'b0);

        // R1: latency of one edge
        src_i = 4'b0001;
        load(mk(8'h00, 5'd0, 2'd0, 2'd1, 1'b0));
        chk("R1 loaded value", pad_o, 1'b1);
        cfg_wdata_i = mk(8'h55, 5'd0, 2'd0, 2'd1, 1'b0);
        cfg_we_i = 1'b1;
        #1 chk("R1 before edge", pad_o, 1'b1);
        @(negedge clk); cfg_we_i = 1'b0;
        chk("R1 after edge", pad_o, 1'b0);

        // R3: every leg assignment, source pattern and select (fan-out included)
        for (int l = 0; l < 256; l++) begin
            load(mk(8'(l), 5'd0, 2'd0, 2'd1, 1'b0));
            for (int s = 0; s < 16; s++) begin
                for (int m = 0; m < 4; m++) begin
                    src_i = 4'(s); mux0_i = m[0]; mux1_i = m[1];
                    #1 chk("R3 leg routing", pad_o, pick(4'(s), 8'(l), 2'(m)));
                end
            end
        end

        // R4: select polarity
        for (int p = 0; p < 4; p++) begin
            load(mk(8'b11100100, {2'(p), 3'b000}, 2'd0, 2'd1, 1'b0));
            for (int s = 0; s < 16; s++) begin
                for (int m = 0; m < 4; m++) begin
                    src_i = 4'(s); mux0_i = m[0]; mux1_i = m[1];
                    #1 chk("R4 select polarity", pad_o, src_i[2'(m) ^ 2'(p)]);
                end
            end
        end

        // R5: expander on
        load(mk(8'b11100100, 5'd0, 2'd0, 2'd1, 1'b1));
        for (int h = 0; h < 4; h++) begin
            for (int c = 0; c < 8; c++) begin
                for (int s = 0; s < 16; s++) begin
                    for (int m = 0; m < 4; m++) begin
                        sel_hi_i = 2'(h); casc_i = 3'(c); src_i = 4'(s);
                        mux0_i = m[0]; mux1_i = m[1];
                        #1;
                        chk("R5 cascade out", casc_o, src_i[m]);
                        chk("R5 group select", pad_o, (h == 0) ? src_i[m] : casc_i[h-1]);
                    end
                end
            end
        end
        // R5: expander off ignores sel_hi
        load(mk(8'b11100100, 5'd0, 2'd0, 2'd1, 1'b0));
        for (int h = 0; h < 4; h++) begin
            for (int s = 0; s < 16; s++) begin
                sel_hi_i = 2'(h); casc_i = 3'b111 ^ 3'(s); src_i = 4'(s);
                mux0_i = 1; mux1_i = 0;
                #1 chk("R5 expander off", pad_o, src_i[1]);
            end
        end
        sel_hi_i = '0;

        // R10: OE with polarity
        for (int p = 0; p < 2; p++) begin
            load(mk(8'h00, {4'b0000, 1'(p)}, 2'd0, 2'd0, 1'b0));
            for (int o = 0; o < 2; o++) begin
                cell_oe_i = 1'(o);
                #1 chk("R10 output enable", pad_oe_o, 1'(o ^ p));
            end
        end
        cell_oe_i = 1'b1;

        // R11: always on, forced low, forced high
        for (int om = 1; om < 4; om++) begin
            load(mk(8'h00, 5'd0, 2'd0, 2'(om), 1'b0));
            for (int s = 0; s < 2; s++) begin
                src_i = 4'(s); cell_oe_i = 1'(s);
                #1;
                chk("R11 driven", pad_oe_o, 1'b1);
                chk("R11 value", pad_o, (om == 1) ? 1'(s) : (om == 3));
            end
        end
        cell_oe_i = 1'b1;

        // R7: latch, leg 0 = src 0, select 0
        mux0_i = 0; mux1_i = 0; cell_clk_i = 1'b0;
        load(mk(8'h00, 5'd0, 2'd1, 2'd1, 1'b0));
        src_i = 4'b0001; cell_clk_i = 1'b1;
        #1 chk("R7 transparent", pad_o, 1'b1);
        src_i = 4'b0000;
        #1 chk("R7 transparent follow", pad_o, 1'b0);
        src_i = 4'b0001;
        @(negedge clk);
        cell_clk_i = 1'b0; src_i = 4'b0000;
        #1 chk("R7 hold", pad_o, 1'b1);
        @(negedge clk);
        chk("R7 hold later", pad_o, 1'b1);

        // R8/R9: register, clock polarity both ways
        for (int p = 0; p < 2; p++) begin
            cell_clk_i = 1'(p);
            load(mk(8'h00, {3'b000, 1'(p), 1'b0}, 2'd2, 2'd1, 1'b0));
            for (int v = 0; v < 4; v++) begin
                src_i = 4'(v & 1); cell_clk_i = 1'(p);
                @(negedge clk);
                cell_clk_i = ~1'(p);
                #1 chk("R8 no capture before edge", pad_o, (v == 0) ? pad_o : 1'((v - 1) & 1));
                @(negedge clk);
                chk("R8 capture on rise", pad_o, 1'(v & 1));
                src_i = ~src_i;
                @(negedge clk);
                chk("R8 no capture while high", pad_o, 1'(v & 1));
            end
        end
        // R9: clock enable low holds
        cell_clk_i = 1'b0;
        load(mk(8'h00, 5'd0, 2'd3, 2'd1, 1'b0));
        src_i = 4'b0001; cell_clk_i = 1'b1;
        @(negedge clk);
        chk("R8 capture alt encoding", pad_o, 1'b1);
        cell_cen_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            cell_clk_i = 1'b0; src_i = 4'b0000;
            @(negedge clk);
            cell_clk_i = 1'b1;
            @(negedge clk);
            chk("R9 enable low holds", pad_o, 1'b1);
        end
        // R9: inverted enable polarity makes low input active
        load(mk(8'h00, 5'b00100, 2'd2, 2'd1, 1'b0));
        cell_clk_i = 1'b0;
        @(negedge clk);
        cell_clk_i = 1'b1;
        @(negedge clk);
        chk("R9 inverted enable captures", pad_o, 1'b0);
        cell_cen_i = 1'b1;

        // R12: reset clears storage
        load(mk(8'h00, 5'd0, 2'd2, 2'd1, 1'b0));
        cell_clk_i = 1'b0; src_i = 4'b0001;
        @(negedge clk);
        cell_clk_i = 1'b1;
        @(negedge clk);
        chk("R12 stored one", pad_o, 1'b1);
        rst_i = 1'b1; cell_clk_i = 1'b0;
        @(negedge clk);
        chk("R2 oe during reset", pad_oe_o, 1'b0);
        rst_i = 1'b0;
        @(negedge clk);
        chk("R2 oe after reset", pad_oe_o, 1'b0);
        load(mk(8'h00, 5'd0, 2'd2, 2'd1, 1'b0));
        chk("R12 cleared", pad_o, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule